// File: doc/BRIEF.md
# Subclass-Masked Multiprocessor Interrupt Router

This block collects interrupt requests from a set of subchannels and hands each one to exactly one of several processors. When a subchannel raises a request it also presents a 3-bit subclass. Every processor supplies an 8-bit subclass mask and an interrupt-enable line. A processor with its enable high takes a pending request whose subclass bit is set in its mask. The router picks the winner and removes the request in one clock edge, so a request never reaches two processors.

A request whose subclass is masked everywhere is not dropped. It stays pending until software fetches it through a shared command port. A test command names one subchannel and claims it whatever the masks say. A probe command fetches the best pending request that the issuing processor's mask accepts. The probe ignores that processor's enable line, so software can drain work without taking an interrupt. A three-state command machine sequences each command: CMD_IDLE (accepting) goes to CMD_EXEC (claim performed) when a command is accepted. CMD_EXEC always goes to CMD_REPLY (response presented for one cycle), and CMD_REPLY always returns to CMD_IDLE.

Top module: `subclass_irq_router`

## Requirements
- R1: After reset no subchannel is pending, `irq_out` and `rsp_valid_out` are low and `cmd_ready_out` is high.
- R2: A high `req_in[s]` at a clock edge makes subchannel s pending from that edge and latches its subclass from `req_class_in[3s+2:3s]`. If s is already pending, the request is re-raised and the new subclass replaces the old one.
- R3: When processor c has `cpu_ien_in[c]` high and bit k of `cpu_mask_in[8c+7:8c]` set, it can accept a pending request of subclass k. For each edge at which it is granted one, `irq_out[c]` is high for the following cycle and `irq_sub_out[c*SW +: SW]` carries the subchannel number.
- R4: When one processor can accept several requests, the lowest subclass number wins. Among requests of that subclass, the lowest subchannel number wins.
- R5: In one cycle processors are served in ascending index order. Each processor picks from the requests not taken by a lower-indexed processor, so no subchannel goes to two processors in that cycle.
- R6: A request is cleared at the edge where it is delivered or claimed, and it is never delivered a second time unless it is raised again.
- R7: A request whose subclass is masked on every processor stays pending for any number of cycles and produces no interrupt.
- R8: Test command (`cmd_op_in` = 0) on a pending subchannel claims and clears it regardless of masks. It reports `rsp_hit_out` = 1 with that subchannel on `rsp_sub_out` and its subclass on `rsp_class_out`.
- R9: Test command on a subchannel that is not pending reports `rsp_hit_out` = 0 and changes no pending state.
- R10: Probe command (`cmd_op_in` = 1) claims the best pending request, under the R4 order, accepted by the issuing processor's mask, whatever that processor's enable. It reports it as in R8, or reports `rsp_hit_out` = 0 and changes nothing if there is none.
- R11: A command is accepted at an edge where `cmd_valid_in` and `cmd_ready_out` are high. `cmd_ready_out` is then low for two cycles, and `rsp_valid_out` is high for exactly the second of them. The claim happens at the middle edge and takes priority over interrupt delivery in that cycle.
- R12: A request raised at the same edge its subchannel is delivered or claimed stays pending with the new subclass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | N_SUB | Per-subchannel raise strobe |
| req_class_in | input | 3*N_SUB | Per-subchannel subclass, 3 bits each |
| cpu_mask_in | input | 8*N_CPU | Per-processor subclass enable mask |
| cpu_ien_in | input | N_CPU | Per-processor interrupt enable |
| cmd_valid_in | input | 1 | Command request |
| cmd_ready_out | output | 1 | Command port can accept |
| cmd_op_in | input | 1 | 0 = test named subchannel, 1 = probe |
| cmd_cpu_in | input | $clog2(N_CPU) | Issuing processor (mask used by probe) |
| cmd_sub_in | input | $clog2(N_SUB) | Subchannel named by test |
| irq_out | output | N_CPU | Per-processor interrupt pulse |
| irq_sub_out | output | N_CPU*$clog2(N_SUB) | Delivered subchannel per processor |
| rsp_valid_out | output | 1 | Command response valid |
| rsp_hit_out | output | 1 | Command found a pending request |
| rsp_sub_out | output | $clog2(N_SUB) | Claimed subchannel |
| rsp_class_out | output | 3 | Subclass of the claimed subchannel |

## Verification
The hardest situation to reach is a collision in one cycle. Either a command claim and an interrupt delivery compete for the same request, or a re-raise lands on the edge that removes the request. Free-running random traffic hits these only by chance. The stimulus therefore parks requests with all enables low and then opens an enable in the exact execute cycle of a test command. It also re-raises a subchannel in the very cycle a processor is enabled for it. Long random runs with sparse enables and shifting masks then build deep pending sets, so the priority chain across processors is exercised with many candidates.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int CLS_W = 3;
    localparam int N_CLS = 8;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_EXEC  = 2'd1,
        CMD_REPLY = 2'd2
    } cmd_state_e;

    typedef enum logic {
        OP_TEST  = 1'b0,
        OP_PROBE = 1'b1
    } cmd_op_e;

endpackage

// File: rtl/irq_pick.sv
// Priority selector: lowest subclass first, then lowest subchannel.
module irq_pick
    import irq_router_pkg::*;
#(
    parameter int N_SUB = 16
) (
    input  logic [N_SUB-1:0]         cand_i,
    input  logic [N_SUB*CLS_W-1:0]   cls_i,
    input  logic [N_CLS-1:0]         mask_i,
    output logic                     hit_o,
    output logic [$clog2(N_SUB)-1:0] idx_o
);
    localparam int SW = $clog2(N_SUB);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int k = 0; k < N_CLS; k++) begin
            for (int s = 0; s < N_SUB; s++) begin
                if (!hit_o && cand_i[s] && mask_i[k] &&
                    (cls_i[s*CLS_W +: CLS_W] == CLS_W'(k))) begin
                    hit_o = 1'b1;
                    idx_o = SW'(s);
                end
            end
        end
    end
endmodule

// File: rtl/irq_pend_store.sv
// Pending flags with latched subclass; a raise overrides a clear.
module irq_pend_store
    import irq_router_pkg::*;
#(
    parameter int N_SUB = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SUB-1:0]         set_i,
    input  logic [N_SUB*CLS_W-1:0]   set_cls_i,
    input  logic [N_SUB-1:0]         clr_i,
    output logic [N_SUB-1:0]         pend_o,
    output logic [N_SUB*CLS_W-1:0]   cls_o
);
    for (genvar s = 0; s < N_SUB; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_o[s]                <= 1'b0;
                cls_o[s*CLS_W +: CLS_W]  <= '0;
            end else if (set_i[s]) begin
                pend_o[s]                <= 1'b1;
                cls_o[s*CLS_W +: CLS_W]  <= set_cls_i[s*CLS_W +: CLS_W];
            end else if (clr_i[s]) begin
                pend_o[s]                <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_cmd_fsm.sv
// Command sequencer for test and probe.
module irq_cmd_fsm
    import irq_router_pkg::*;
#(
    parameter int N_SUB = 16,
    parameter int N_CPU = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid_i,
    input  logic                     cmd_op_i,
    input  logic [$clog2(N_CPU)-1:0] cmd_cpu_i,
    input  logic [$clog2(N_SUB)-1:0] cmd_sub_i,
    input  logic [N_SUB-1:0]         pend_i,
    input  logic [N_SUB*CLS_W-1:0]   cls_i,
    input  logic [N_CPU*N_CLS-1:0]   mask_i,
    output logic                     ready_o,
    output logic [N_SUB-1:0]         claim_o,
    output logic                     rsp_valid_o,
    output logic                     rsp_hit_o,
    output logic [$clog2(N_SUB)-1:0] rsp_sub_o,
    output logic [CLS_W-1:0]         rsp_cls_o
);
    localparam int SW = $clog2(N_SUB);
    localparam int CW = $clog2(N_CPU);

    cmd_state_e      state_q, state_d;
    cmd_op_e         op_q;
    logic [CW-1:0]   cpu_q;
    logic [SW-1:0]   sub_q;
    logic            probe_hit;
    logic [SW-1:0]   probe_idx;
    logic            exec_hit;
    logic [SW-1:0]   exec_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE:  if (cmd_valid_i) state_d = CMD_EXEC;
            CMD_EXEC:  state_d = CMD_REPLY;
            CMD_REPLY: state_d = CMD_IDLE;
            default:   state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_TEST;
            cpu_q <= '0;
            sub_q <= '0;
        end else if (state_q == CMD_IDLE && cmd_valid_i) begin
            op_q  <= cmd_op_e'(cmd_op_i);
            cpu_q <= cmd_cpu_i;
            sub_q <= cmd_sub_i;
        end
    end

    irq_pick #(.N_SUB(N_SUB)) i_probe_pick (
        .cand_i (pend_i),
        .cls_i  (cls_i),
        .mask_i (mask_i[cpu_q*N_CLS +: N_CLS]),
        .hit_o  (probe_hit),
        .idx_o  (probe_idx)
    );

    always_comb begin
        ready_o     = (state_q == CMD_IDLE);
        rsp_valid_o = (state_q == CMD_REPLY);
        claim_o     = '0;
        exec_hit    = 1'b0;
        exec_idx    = sub_q;
        unique case (state_q)
            CMD_EXEC: begin
                if (op_q == OP_TEST) begin
                    exec_hit = pend_i[sub_q];
                    exec_idx = sub_q;
                end else begin
                    exec_hit = probe_hit;
                    exec_idx = probe_idx;
                end
                claim_o[exec_idx] = exec_hit;
            end
            CMD_IDLE, CMD_REPLY: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit_o <= 1'b0;
            rsp_sub_o <= '0;
            rsp_cls_o <= '0;
        end else if (state_q == CMD_EXEC) begin
            rsp_hit_o <= exec_hit;
            rsp_sub_o <= exec_idx;
            rsp_cls_o <= cls_i[exec_idx*CLS_W +: CLS_W];
        end
    end
endmodule

// File: rtl/subclass_irq_router.sv
module subclass_irq_router
    import irq_router_pkg::*;
#(
    parameter int N_SUB = 16,
    parameter int N_CPU = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_SUB-1:0]               req_in,
    input  logic [N_SUB*3-1:0]             req_class_in,
    input  logic [N_CPU*8-1:0]             cpu_mask_in,
    input  logic [N_CPU-1:0]               cpu_ien_in,
    input  logic                           cmd_valid_in,
    output logic                           cmd_ready_out,
    input  logic                           cmd_op_in,
    input  logic [$clog2(N_CPU)-1:0]       cmd_cpu_in,
    input  logic [$clog2(N_SUB)-1:0]       cmd_sub_in,
    output logic [N_CPU-1:0]               irq_out,
    output logic [N_CPU*$clog2(N_SUB)-1:0] irq_sub_out,
    output logic                           rsp_valid_out,
    output logic                           rsp_hit_out,
    output logic [$clog2(N_SUB)-1:0]       rsp_sub_out,
    output logic [2:0]                     rsp_class_out
);
    localparam int SW = $clog2(N_SUB);

    logic [N_SUB-1:0]       pend_w;
    logic [N_SUB*CLS_W-1:0] cls_w;
    logic [N_SUB-1:0]       claim_w;
    logic [N_SUB-1:0]       clr_w;
    logic [N_SUB-1:0]       avail [N_CPU+1];
    logic [N_CPU-1:0]       g_hit;
    logic [N_CPU*SW-1:0]    g_idx;

    irq_pend_store #(.N_SUB(N_SUB)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (req_in),
        .set_cls_i (req_class_in),
        .clr_i     (clr_w),
        .pend_o    (pend_w),
        .cls_o     (cls_w)
    );

    irq_cmd_fsm #(.N_SUB(N_SUB), .N_CPU(N_CPU)) i_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_in),
        .cmd_op_i    (cmd_op_in),
        .cmd_cpu_i   (cmd_cpu_in),
        .cmd_sub_i   (cmd_sub_in),
        .pend_i      (pend_w),
        .cls_i       (cls_w),
        .mask_i      (cpu_mask_in),
        .ready_o     (cmd_ready_out),
        .claim_o     (claim_w),
        .rsp_valid_o (rsp_valid_out),
        .rsp_hit_o   (rsp_hit_out),
        .rsp_sub_o   (rsp_sub_out),
        .rsp_cls_o   (rsp_class_out)
    );

    // Command claim is removed before any processor chooses.
    assign avail[0] = pend_w & ~claim_w;

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic [N_SUB-1:0] cand;
        logic [N_SUB-1:0] taken;
        assign cand = avail[c] & {N_SUB{cpu_ien_in[c]}};

        irq_pick #(.N_SUB(N_SUB)) i_pick (
            .cand_i (cand),
            .cls_i  (cls_w),
            .mask_i (cpu_mask_in[c*N_CLS +: N_CLS]),
            .hit_o  (g_hit[c]),
            .idx_o  (g_idx[c*SW +: SW])
        );

        always_comb begin
            taken = '0;
            taken[g_idx[c*SW +: SW]] = g_hit[c];
        end
        assign avail[c+1] = avail[c] & ~taken;
    end

    assign clr_w = pend_w & ~avail[N_CPU];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out     <= '0;
            irq_sub_out <= '0;
        end else begin
            irq_out     <= g_hit;
            irq_sub_out <= g_idx;
        end
    end
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
    parameter int N_SUB = 16,
    parameter int N_CPU = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [N_SUB-1:0]               req_in,
    input logic [N_SUB-1:0]               pend,
    input logic [N_CPU-1:0]               irq,
    input logic [N_CPU*$clog2(N_SUB)-1:0] irq_sub,
    input logic                           rsp_valid,
    input logic                           rsp_hit,
    input logic [$clog2(N_SUB)-1:0]       rsp_sub,
    input logic                           cmd_valid,
    input logic                           cmd_ready
);
    localparam int SW = $clog2(N_SUB);

    logic [N_SUB-1:0] pend_d1;
    logic [N_SUB-1:0] taken_now;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_d1 <= '0;
        else        pend_d1 <= pend;
    end

    always_comb begin
        taken_now = '0;
        for (int c = 0; c < N_CPU; c++)
            if (irq[c]) taken_now[irq_sub[c*SW +: SW]] = 1'b1;
        if (rsp_valid && rsp_hit) taken_now[rsp_sub] = 1'b1;
    end

    assert_rsp_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_ready_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_hit_was_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> pend_d1[rsp_sub]);

    for (genvar c = 0; c < N_CPU; c++) begin : g_c
        assert_irq_was_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> pend_d1[irq_sub[c*SW +: SW]]);
        for (genvar d = c + 1; d < N_CPU; d++) begin : g_d
            assert_unique_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (irq[c] && irq[d]) |-> (irq_sub[c*SW +: SW] != irq_sub[d*SW +: SW]));
        end
    end

    for (genvar s = 0; s < N_SUB; s++) begin : g_s
        assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            req_in[s] |=> pend[s]);
        assert_drop_explained_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_d1[s] && !pend[s]) |-> taken_now[s]);
    end
endmodule

bind subclass_irq_router irq_router_checker #(.N_SUB(N_SUB), .N_CPU(N_CPU)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_in    (req_in),
    .pend      (pend_w),
    .irq       (irq_out),
    .irq_sub   (irq_sub_out),
    .rsp_valid (rsp_valid_out),
    .rsp_hit   (rsp_hit_out),
    .rsp_sub   (rsp_sub_out),
    .cmd_valid (cmd_valid_in),
    .cmd_ready (cmd_ready_out)
);

// File: tb/test_subclass_irq_router.sv
`timescale 1ns/1ps
module test_subclass_irq_router;
    localparam int NS = 16;
    localparam int NC = 4;
    localparam int SW = 4;
    localparam int CW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NS-1:0]   req;
    logic [NS*3-1:0] req_cls;
    logic [NC*8-1:0] mask;
    logic [NC-1:0]   ien;
    logic            cmd_valid;
    logic            cmd_ready;
    logic            cmd_op;
    logic [CW-1:0]   cmd_cpu;
    logic [SW-1:0]   cmd_sub;
    logic [NC-1:0]   irq;
    logic [NC*SW-1:0] irq_sub;
    logic            rsp_valid, rsp_hit;
    logic [SW-1:0]   rsp_sub;
    logic [2:0]      rsp_cls;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    subclass_irq_router #(.N_SUB(NS), .N_CPU(NC)) i_subclass_irq_router (
        .clk(clk), .rst_n(rst_n), .req_in(req), .req_class_in(req_cls),
        .cpu_mask_in(mask), .cpu_ien_in(ien), .cmd_valid_in(cmd_valid),
        .cmd_ready_out(cmd_ready), .cmd_op_in(cmd_op), .cmd_cpu_in(cmd_cpu),
        .cmd_sub_in(cmd_sub), .irq_out(irq), .irq_sub_out(irq_sub),
        .rsp_valid_out(rsp_valid), .rsp_hit_out(rsp_hit),
        .rsp_sub_out(rsp_sub), .rsp_class_out(rsp_cls)
    );

    // Reference model state
    logic [NS-1:0] m_pend;
    logic [2:0]    m_cls [NS];
    int            m_st;
    logic          m_op;
    int            m_cpu, m_sub;
    logic [NC-1:0] e_irq;
    int            e_sub [NC];
    logic          e_hit;
    int            e_rsub;
    logic [2:0]    e_rcls;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void best(input logic [NS-1:0] cand, input logic [7:0] mk,
                                 output logic hit, output int idx);
        hit = 1'b0;
        idx = 0;
        for (int k = 0; k < 8; k++)
            for (int s = 0; s < NS; s++)
                if (!hit && cand[s] && mk[k] && m_cls[s] == 3'(k)) begin
                    hit = 1'b1;
                    idx = s;
                end
    endfunction

    // Called at a negedge with inputs set; advances one edge and compares.
    task automatic cycle(input string tag);
        logic [NS-1:0] avail;
        logic h;
        int ix;
        avail = m_pend;
        if (m_st == 1) begin
            if (m_op == 1'b0) begin
                h = m_pend[m_sub];
                ix = m_sub;
            end else begin
                best(m_pend, mask[m_cpu*8 +: 8], h, ix);
            end
            e_hit = h;
            e_rsub = ix;
            e_rcls = m_cls[ix];
            if (h) avail[ix] = 1'b0;
        end
        for (int c = 0; c < NC; c++) begin
            e_irq[c] = 1'b0;
            e_sub[c] = 0;
            if (ien[c]) begin
                best(avail, mask[c*8 +: 8], h, ix);
                if (h) begin
                    e_irq[c] = 1'b1;
                    e_sub[c] = ix;
                    avail[ix] = 1'b0;
                end
            end
        end
        for (int s = 0; s < NS; s++)
            if (req[s]) begin
                avail[s] = 1'b1;
                m_cls[s] = req_cls[s*3 +: 3];
            end
        m_pend = avail;
        if (m_st == 0) begin
            if (cmd_valid) begin
                m_st = 1;
                m_op = cmd_op;
                m_cpu = int'(cmd_cpu);
                m_sub = int'(cmd_sub);
            end
        end else if (m_st == 1) m_st = 2;
        else m_st = 0;

        @(posedge clk);
        #1;
        chk(irq == e_irq, tag, "irq vector", int'(irq), int'(e_irq));
        for (int c = 0; c < NC; c++)
            if (e_irq[c])
                chk(int'(irq_sub[c*SW +: SW]) == e_sub[c], tag, "irq subchannel",
                    int'(irq_sub[c*SW +: SW]), e_sub[c]);
        chk(cmd_ready == (m_st == 0), tag, "cmd ready", int'(cmd_ready), int'(m_st == 0));
        chk(rsp_valid == (m_st == 2), tag, "rsp valid", int'(rsp_valid), int'(m_st == 2));
        if (m_st == 2) begin
            chk(rsp_hit == e_hit, tag, "rsp hit", int'(rsp_hit), int'(e_hit));
            if (e_hit) begin
                chk(int'(rsp_sub) == e_rsub, tag, "rsp subchannel", int'(rsp_sub), e_rsub);
                chk(rsp_cls == e_rcls, tag, "rsp subclass", int'(rsp_cls), int'(e_rcls));
            end
        end
        @(negedge clk);
        req = '0;
        cmd_valid = 1'b0;
    endtask

    task automatic raise(input int s, input int k);
        req[s] = 1'b1;
        req_cls[s*3 +: 3] = 3'(k);
    endtask

    task automatic command(input bit op, input int cpu, input int sub, input string tag);
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_cpu = CW'(cpu);
        cmd_sub = SW'(sub);
        cycle(tag);
        cycle(tag);
        cycle(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        req = '0; req_cls = '0; mask = '0; ien = '0;
        cmd_valid = 1'b0; cmd_op = 1'b0; cmd_cpu = '0; cmd_sub = '0;
        m_pend = '0; m_st = 0; m_op = 1'b0; m_cpu = 0; m_sub = 0;
        e_hit = 1'b0; e_rsub = 0; e_rcls = '0;
        for (int s = 0; s < NS; s++) m_cls[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(cmd_ready == 1'b1 && irq == '0 && rsp_valid == 1'b0, "R1", "reset outputs",
            int'({cmd_ready, irq, rsp_valid}), 32);
        cycle("R1");

        // R2/R3: only cpu2 enabled for subclass 3
        mask = {4{8'h08}};
        ien = 4'b0100;
        raise(5, 3);
        cycle("R2");
        cycle("R3");
        cycle("R3");

        // R4: park three requests, then open cpu0
        ien = '0;
        mask = {4{8'hFF}};
        raise(9, 1); raise(4, 1); raise(2, 6);
        cycle("R4");
        ien = 4'b0001;
        repeat (4) cycle("R4");

        // R5/R6: three parked, all cpus open at once
        ien = '0;
        raise(12, 2); raise(3, 0); raise(10, 2);
        cycle("R5");
        ien = 4'b1111;
        cycle("R5");
        repeat (3) cycle("R6");

        // R7: fully masked request persists
        mask = '0;
        raise(7, 2);
        cycle("R7");
        repeat (20) cycle("R7");
        // R8: test claims it regardless of masks
        command(1'b0, 3, 7, "R8");
        // R9: second test misses, nothing changes
        command(1'b0, 3, 7, "R9");
        command(1'b0, 0, 11, "R9");

        // R10: probe from cpu1 with enable low
        ien = '0;
        raise(1, 4); raise(13, 4);
        cycle("R10");
        mask[8 +: 8] = 8'h10;
        command(1'b1, 1, 0, "R10");
        command(1'b1, 3, 0, "R10");
        command(1'b1, 1, 0, "R10");
        command(1'b1, 1, 0, "R10");

        // R12: re-raise in the cycle of delivery
        mask = '0;
        mask[7:0] = 8'hFF;
        raise(6, 5);
        cycle("R12");
        ien = 4'b0001;
        raise(6, 0);
        cycle("R12");
        cycle("R12");
        cycle("R12");

        // R11: command claim beats delivery in its execute cycle
        ien = '0;
        mask[7:0] = 8'h01;
        raise(8, 0);
        cycle("R11");
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_cpu = '0; cmd_sub = SW'(8);
        cycle("R11");
        ien = 4'b0001;
        cycle("R11");
        cycle("R11");
        cycle("R11");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) raise($urandom_range(0, NS-1), $urandom_range(0, 7));
            if ($urandom_range(0, 5) == 0) raise($urandom_range(0, NS-1), $urandom_range(0, 7));
            for (int c = 0; c < NC; c++) ien[c] = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 49) == 0) mask = {$urandom(), $urandom()} >> 32;
            if (m_st == 0 && $urandom_range(0, 5) == 0) begin
                cmd_valid = 1'b1;
                cmd_op = 1'($urandom_range(0, 1));
                cmd_cpu = CW'($urandom_range(0, NC-1));
                cmd_sub = SW'($urandom_range(0, NS-1));
            end
            cycle("R4");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule